// File: doc/BRIEF.md
# Checksummed Serial Frame Parser

This block sits behind a UART receiver and turns its byte stream into whole messages. It hunts for a start-of-frame byte, reads one header byte holding a message id and a payload length, gathers that many payload bytes, and then compares a trailing checksum byte with the running sum it has built up. When the two match, it presents the id, length and payload on its outputs with a one-cycle valid pulse. When they do not match, it drops the frame and waits for the next start byte.

The receiver's per-byte error flags (parity, framing, overrun) never stop a byte from being parsed. Each flag instead advances its own saturating counter. Checksum mismatches are counted the same way. A synchronous resync input sends the parser back to hunting at any time. The last delivered message is held on the outputs until the next one replaces it.

Top module: `frame_parser`

## Requirements
- R1: After reset the parser is hunting, `msg_valid` is 0, and all four counters read 0.
- R2: While hunting, every byte other than the start value `SOF` (default 8'h02) is discarded, so a sequence that has no start byte produces no message.
- R3: The byte after `SOF` is the header: bits 7:4 give the id and bits 3:0 give the payload length. On delivery these appear on `msg_id` and `msg_len`.
- R4: The checksum is the header byte plus every payload byte, modulo 256. A message is delivered only when the byte after the payload equals this sum. `msg_valid` rises in the cycle after the checksum byte is taken and stays high for exactly one cycle.
- R5: A header with length 0 is followed directly by the checksum byte.
- R6: Exactly `len` payload bytes are collected. Payload byte i appears on `msg_data[8i+7:8i]`, and bytes at positions at or beyond `len` read as 0.
- R7: A byte equal to `SOF` inside the payload is treated as ordinary data.
- R8: On a checksum mismatch there is no valid pulse, `cnt_badsum` increments, and the parser returns to hunting, so the next correct frame is delivered.
- R9: `resync` puts the parser back into hunting. It takes priority over a byte offered in the same cycle, so that byte is not parsed.
- R10: A byte flagged with a parity, framing or overrun error is still parsed normally. Each flag increments its own counter, which saturates at its maximum value.
- R11: `msg_id`, `msg_len` and `msg_data` hold the last delivered message until the next delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resync | input | 1 | Synchronous return to hunting |
| in_valid | input | 1 | A received byte is offered this cycle |
| in_byte | input | 8 | Received byte |
| in_parity_err | input | 1 | Parity error flag for the byte |
| in_frame_err | input | 1 | Framing error flag for the byte |
| in_overrun_err | input | 1 | Overrun flag for the byte |
| msg_valid | output | 1 | One-cycle pulse for a delivered message |
| msg_id | output | 8-LEN_W | Message id |
| msg_len | output | LEN_W | Payload length |
| msg_data | output | 8*(2**LEN_W-1) | Payload, byte 0 in the low bits |
| cnt_parity | output | CNT_W | Saturating parity error count |
| cnt_frame | output | CNT_W | Saturating framing error count |
| cnt_overrun | output | CNT_W | Saturating overrun count |
| cnt_badsum | output | CNT_W | Saturating checksum mismatch count |

## Verification
The bench builds the parser with CNT_W=4, which makes every counter saturate after 15 events. This brings the saturation corner within reach in a few dozen bytes. It keeps LEN_W=4 and the default start value, so the full 15-byte payload, a zero-length frame and start values placed inside the payload are all exercised at their natural widths. Random frames mix good and corrupted checksums with garbage bytes between frames and error flags on individual bytes.

// File: rtl/frame_parser.sv
module frame_parser #(
  parameter int          LEN_W = 4,
  parameter logic [7:0]  SOF   = 8'h02,
  parameter int          CNT_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             resync,
  input  logic                             in_valid,
  input  logic [7:0]                       in_byte,
  input  logic                             in_parity_err,
  input  logic                             in_frame_err,
  input  logic                             in_overrun_err,
  output logic                             msg_valid,
  output logic [8-LEN_W-1:0]               msg_id,
  output logic [LEN_W-1:0]                 msg_len,
  output logic [8*((1<<LEN_W)-1)-1:0]      msg_data,
  output logic [CNT_W-1:0]                 cnt_parity,
  output logic [CNT_W-1:0]                 cnt_frame,
  output logic [CNT_W-1:0]                 cnt_overrun,
  output logic [CNT_W-1:0]                 cnt_badsum
);
  localparam int ID_W = 8 - LEN_W;
  localparam int MAXP = (1 << LEN_W) - 1;
  localparam logic [CNT_W-1:0] CMAX = '1;

  typedef enum logic [1:0] {S_HUNT, S_HDR, S_DATA, S_SUM} st_t;

  st_t              st;
  logic [ID_W-1:0]  id_q;
  logic [LEN_W-1:0] len_q, idx;
  logic [7:0]       sum;
  logic [7:0]       pay [MAXP];

  wire take      = in_valid & ~resync;
  wire sum_ok    = (in_byte == sum);
  wire last_data = (idx == len_q - LEN_W'(1));
  wire deliver   = take & (st == S_SUM) & sum_ok;
  wire mismatch  = take & (st == S_SUM) & ~sum_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_HUNT;
      id_q  <= '0;
      len_q <= '0;
      idx   <= '0;
      sum   <= '0;
    end else if (resync) begin
      st <= S_HUNT;
    end else if (in_valid) begin
      case (st)
        S_HUNT: if (in_byte == SOF) st <= S_HDR;
        S_HDR: begin
          id_q  <= in_byte[7:LEN_W];
          len_q <= in_byte[LEN_W-1:0];
          idx   <= '0;
          sum   <= in_byte;
          st    <= (in_byte[LEN_W-1:0] == '0) ? S_SUM : S_DATA;
        end
        S_DATA: begin
          sum <= sum + in_byte;
          idx <= idx + LEN_W'(1);
          if (last_data) st <= S_SUM;
        end
        default: st <= S_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAXP; i++) pay[i] <= '0;
    end else if (take && st == S_HDR) begin
      for (int i = 0; i < MAXP; i++) pay[i] <= '0;
    end else if (take && st == S_DATA) begin
      pay[idx] <= in_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_id    <= '0;
      msg_len   <= '0;
      msg_data  <= '0;
    end else begin
      msg_valid <= deliver;
      if (deliver) begin
        msg_id  <= id_q;
        msg_len <= len_q;
        for (int i = 0; i < MAXP; i++) msg_data[8*i +: 8] <= pay[i];
      end
    end
  end

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c, input logic ev);
    return (ev && c != CMAX) ? c + CNT_W'(1) : c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_parity  <= '0;
      cnt_frame   <= '0;
      cnt_overrun <= '0;
      cnt_badsum  <= '0;
    end else begin
      cnt_parity  <= bump(cnt_parity,  in_valid & in_parity_err);
      cnt_frame   <= bump(cnt_frame,   in_valid & in_frame_err);
      cnt_overrun <= bump(cnt_overrun, in_valid & in_overrun_err);
      cnt_badsum  <= bump(cnt_badsum,  mismatch);
    end
  end
endmodule

module frame_parser_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             resync,
  input logic             in_valid,
  input logic             msg_valid,
  input logic [CNT_W-1:0] cnt_parity,
  input logic [CNT_W-1:0] cnt_frame,
  input logic [CNT_W-1:0] cnt_overrun,
  input logic [CNT_W-1:0] cnt_badsum
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> !msg_valid); // R4
  AST_NO_BYTE_NO_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !msg_valid); // R2
  AST_RESYNC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !msg_valid); // R9
  AST_BADSUM_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || resync) |=> $stable(cnt_badsum)); // R8
  AST_PAR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_parity == CMAX) |=> (cnt_parity == CMAX)); // R10
  AST_FRM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_frame == $past(cnt_frame) || cnt_frame == $past(cnt_frame) + CNT_W'(1))); // R10
  AST_OVR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt_overrun)); // R10
endmodule

bind frame_parser frame_parser_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .resync(resync), .in_valid(in_valid),
  .msg_valid(msg_valid), .cnt_parity(cnt_parity), .cnt_frame(cnt_frame),
  .cnt_overrun(cnt_overrun), .cnt_badsum(cnt_badsum));

// File: tb/frame_parser_test.sv
`timescale 1ns/1ps
module frame_parser_test;
  localparam int CW = 4;
  localparam int LW = 4;
  localparam int MP = 15;
  localparam logic [7:0] SOFB = 8'h02;
  localparam logic [CW-1:0] CMX = '1;

  logic clk = 0, rst_n = 0, resync = 0, in_valid = 0;
  logic [7:0] in_byte = 0;
  logic pe = 0, fe = 0, oe = 0;
  logic msg_valid;
  logic [3:0] msg_id, msg_len;
  logic [8*MP-1:0] msg_data;
  logic [CW-1:0] cnt_parity, cnt_frame, cnt_overrun, cnt_badsum;

  frame_parser #(.LEN_W(LW), .SOF(SOFB), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .resync(resync), .in_valid(in_valid), .in_byte(in_byte),
    .in_parity_err(pe), .in_frame_err(fe), .in_overrun_err(oe),
    .msg_valid(msg_valid), .msg_id(msg_id), .msg_len(msg_len), .msg_data(msg_data),
    .cnt_parity(cnt_parity), .cnt_frame(cnt_frame), .cnt_overrun(cnt_overrun),
    .cnt_badsum(cnt_badsum));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [CW-1:0] e_par = 0, e_frm = 0, e_ovr = 0, e_bad = 0;
  logic [7:0] pl [MP];
  logic [8*MP-1:0] last_data;
  logic [3:0] last_id, last_len;

  function automatic logic [CW-1:0] sinc(input logic [CW-1:0] c);
    return (c == CMX) ? c : c + CW'(1);
  endfunction

  function automatic logic [7:0] frame_sum(input logic [3:0] id, input logic [3:0] len);
    logic [7:0] s = {id, len};
    for (int i = 0; i < MP; i++) if (i < len) s = s + pl[i];
    return s;
  endfunction

  function automatic logic [8*MP-1:0] exp_data(input logic [3:0] len);
    logic [8*MP-1:0] d = '0;
    for (int i = 0; i < MP; i++) if (i < len) d[8*i +: 8] = pl[i];
    return d;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic p = 0, input logic f = 0, input logic o = 0);
    in_valid = 1; in_byte = b; pe = p; fe = f; oe = o;
    @(negedge clk);
    in_valid = 0; pe = 0; fe = 0; oe = 0;
    if (p) e_par = sinc(e_par);
    if (f) e_frm = sinc(e_frm);
    if (o) e_ovr = sinc(e_ovr);
  endtask

  task automatic check_counters(input string req);
    check({req, " parity count"}, cnt_parity, e_par);
    check({req, " framing count"}, cnt_frame, e_frm);
    check({req, " overrun count"}, cnt_overrun, e_ovr);
    check({req, " badsum count"}, cnt_badsum, e_bad);
  endtask

  task automatic send_frame(input string req, input logic [3:0] id, input logic [3:0] len,
                            input logic bad, input logic flags);
    logic [7:0] s = frame_sum(id, len);
    send(SOFB);
    send({id, len}, flags & 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < MP; i++) if (i < len) send(pl[i], 1'b0, flags & i[0], flags & ~i[0]);
    send(bad ? s ^ 8'h5A : s);
    if (bad) begin
      e_bad = sinc(e_bad);
      check({req, " no pulse on bad sum"}, msg_valid, 0);
      check({req, " badsum count"}, cnt_badsum, e_bad);
      check({req, " held id"}, msg_id, last_id);
    end else begin
      last_id = id; last_len = len; last_data = exp_data(len);
      check({req, " pulse"}, msg_valid, 1);
      check({req, " id R3"}, msg_id, id);
      check({req, " len R3"}, msg_len, len);
      check({req, " data R6"}, msg_data, last_data);
    end
    @(negedge clk);
    check({req, " pulse ends R4"}, msg_valid, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    last_id = 0; last_len = 0; last_data = 0;
    repeat (3) @(negedge clk);
    check("R1 valid at reset", msg_valid, 0);
    check_counters("R1");
    rst_n = 1;
    @(negedge clk);

    // R2: frame-shaped bytes without a start byte
    send(8'h31); send(8'hAA); send(8'h31 + 8'hAA);
    check("R2 no message without SOF", msg_valid, 0);
    @(negedge clk);
    check("R2 still none", msg_valid, 0);

    // R5: zero-length
    send_frame("R5 zero length", 4'h7, 4'h0, 0, 0);

    // R6: full length
    for (int i = 0; i < MP; i++) pl[i] = 8'h10 + 8'(i);
    send_frame("R6 full length", 4'hC, 4'hF, 0, 0);

    // R6: short frame clears stale bytes
    pl[0] = 8'hEE; pl[1] = 8'hDD;
    send_frame("R6 short frame", 4'h3, 4'h2, 0, 0);

    // R7: SOF in payload
    pl[0] = SOFB; pl[1] = SOFB; pl[2] = 8'h99;
    send_frame("R7 SOF in payload", 4'h1, 4'h3, 0, 0);

    // R8: bad then good
    pl[0] = 8'h44;
    send_frame("R8 bad sum", 4'h2, 4'h1, 1, 0);
    send_frame("R8 good after bad", 4'h2, 4'h1, 0, 0);

    // R9: resync mid-payload
    pl[0] = 8'h55; pl[1] = 8'h66;
    send(SOFB); send(8'h42); send(8'h55);
    resync = 1; @(negedge clk); resync = 0;
    send(8'h66); send(8'h42 + 8'h55 + 8'h66);
    check("R9 no message after resync", msg_valid, 0);
    check("R9 nothing counted as bad", cnt_badsum, e_bad);
    // R9: resync in the checksum byte's cycle
    send(SOFB); send(8'h42); send(8'h55); send(8'h66);
    in_valid = 1; in_byte = 8'h42 + 8'h55 + 8'h66; resync = 1;
    @(negedge clk); in_valid = 0; resync = 0;
    check("R9 resync beats checksum byte", msg_valid, 0);
    send_frame("R9 recovery", 4'h4, 4'h2, 0, 0);

    // R11: hold outputs across garbage
    send(8'hF0); send(8'h13); @(negedge clk);
    check("R11 id held", msg_id, last_id);
    check("R11 len held", msg_len, last_len);
    check("R11 data held", msg_data, last_data);

    // R10: flagged bytes still parsed
    pl[0] = 8'h01; pl[1] = 8'h02; pl[2] = 8'h03; pl[3] = 8'h04;
    send_frame("R10 flagged bytes parsed", 4'h9, 4'h4, 0, 1);
    check_counters("R10");
    // R10 saturation
    for (int i = 0; i < 20; i++) send(8'hF1, 1'b1, 1'b1, i[0]);
    check_counters("R10 saturation");
    check("R10 parity at max", cnt_parity, CMX);

    // random frames
    for (int n = 0; n < 60; n++) begin
      logic [3:0] rid = 4'($urandom);
      logic [3:0] rl = 4'($urandom);
      int g = $urandom_range(0, 3);
      for (int k = 0; k < g; k++) begin
        logic [7:0] gb = 8'($urandom);
        if (gb == SOFB) gb = gb ^ 8'h01;
        send(gb, 1'($urandom), 1'($urandom), 1'($urandom));
      end
      for (int i = 0; i < MP; i++) pl[i] = 8'($urandom);
      send_frame("R4 random frame", rid, rl, ($urandom_range(0, 3) == 0), 1'($urandom));
    end
    check_counters("R8 R10 random");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule